// File: doc/BRIEF.md
# Edge-Capturing GPIO Controller

This block is a 32-pin general-purpose I/O controller with a simple word-wide register bus. Each pin can be set as an input or an output. An output can be driven push-pull or open-drain. Every input is passed through a two-stage synchroniser. Transitions on each pin are caught in a sticky event bit. Each pin selects whether only falling transitions count, or transitions in both directions. Software masks the event bits, and one level-sensitive interrupt line reports when any unmasked event is pending.

The bus is a single-cycle slave. A write commits on the clock edge at which `bus_sel` and `bus_wr` are both high. A read is combinational from the address. In every register, pin n occupies bit 31-n, so pin 0 is the most significant bit. The pin vectors at the ports are indexed by pin number. The pad cells that merge `pin_oe` and `pin_out` into a real pin sit outside this block.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Pin n (index n of `pin_in`, `pin_oe` and `pin_out`) maps to bit 31-n of every register, so a change on `pin_in[0]` shows up in bit 31.
- R2: The registers sit at these byte offsets: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask and 0x14 edge mode. Every other offset reads zero and ignores writes. Direction, open-drain, mask and edge mode read back the value last written.
- R3: Reset clears every register. While reset is held, `pin_oe` is zero and `irq` is low.
- R4: A direction bit of 1 makes its pin an output with `pin_oe` high and `pin_out` equal to the data bit. A direction bit of 0 leaves the pin undriven.
- R5: When an output pin has its open-drain bit set, a data bit of 1 releases the pin (`pin_oe` low) and a data bit of 0 drives it low.
- R6: A read of the data register returns the written value for output pins. For input pins it returns the synchronised level, which follows a pin change after two clock edges.
- R7: An edge-mode bit of 0 captures both rising and falling transitions. The event bit becomes visible after the third clock edge following the pin change.
- R8: An edge-mode bit of 1 captures falling transitions only. Rising transitions leave the event bit clear.
- R9: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. Event bits never clear in any other way.
- R10: If a capture and a write-one-to-clear hit the same event bit on the same clock edge, the bit stays set.
- R11: `irq` is high exactly while some bit is set in both the event register and the mask register.
- R12: Writing all ones to the event register and then zero to the mask register, with quiet pins, leaves the event register reading zero and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Asynchronous pin levels, index = pin number |
| pin_oe | output | 32 | Output enable per pin |
| pin_out | output | 32 | Output value per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The bench goes after the pin-to-bit reversal. A design that did not reverse would report a change on pin 0 in bit 0. It also checks the exact latency, two edges for the level and three for the event. An extra or missing synchroniser stage would be seen one cycle early or late. A clear write is made to land on the very edge on which a capture arrives. A design that lets the clear win would lose that event. Falling-only pins get a rising transition, which a mode-blind design would latch. Open-drain outputs with data 1 are checked to be released rather than driven high. Writes of zero to the event register are checked to leave pending bits intact.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam logic [7:0] OFS_DIR = 8'h00;
    localparam logic [7:0] OFS_ODN = 8'h04;
    localparam logic [7:0] OFS_DAT = 8'h08;
    localparam logic [7:0] OFS_EVT = 8'h0C;
    localparam logic [7:0] OFS_MSK = 8'h10;
    localparam logic [7:0] OFS_EDG = 8'h14;

    typedef enum logic [2:0] {
        SEL_DIR,
        SEL_ODN,
        SEL_DAT,
        SEL_EVT,
        SEL_MSK,
        SEL_EDG,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            OFS_DIR: return SEL_DIR;
            OFS_ODN: return SEL_ODN;
            OFS_DAT: return SEL_DAT;
            OFS_EVT: return SEL_EVT;
            OFS_MSK: return SEL_MSK;
            OFS_EDG: return SEL_EDG;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Two-stage synchroniser followed by a history stage for edge detection.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] hist;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
        st_d.hist   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.stable;
    assign rise  = st_q.stable & ~st_q.hist;
    assign fall  = ~st_q.stable & st_q.hist;

endmodule

// File: rtl/gpio_evt_reg.sv
// Sticky event bits: capture sets, write-one clears, capture wins.
module gpio_evt_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] evt
);

    logic [W-1:0] evt_d, evt_q;

    always_comb begin
        evt_d = (evt_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign evt = evt_q;

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int N_PINS = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pin_out,
    output logic              irq
);

    localparam int MSB = N_PINS - 1;

    typedef struct packed {
        logic [N_PINS-1:0] dir;
        logic [N_PINS-1:0] odn;
        logic [N_PINS-1:0] dat;
        logic [N_PINS-1:0] msk;
        logic [N_PINS-1:0] edg;
    } regs_t;

    regs_t    rg_d, rg_q;
    reg_sel_e sel;
    logic     wr_en;

    logic [N_PINS-1:0] pin_r, oe_r, out_r;
    logic [N_PINS-1:0] lvl_v, rise_v, fall_v, cap_v, clr_v, evt_v;
    logic [N_PINS-1:0] dir_v, odn_v, dat_v, msk_v, edg_v;

    // pin n <-> register bit MSB-n
    for (genvar g = 0; g < N_PINS; g++) begin : g_pinmap
        assign pin_r[MSB-g] = pin_in[g];
        assign pin_oe[g]    = oe_r[MSB-g];
        assign pin_out[g]   = out_r[MSB-g];
    end

    assign sel   = decode_ofs(8'(bus_addr));
    assign wr_en = bus_sel && bus_wr;

    assign dir_v = rg_q.dir;
    assign odn_v = rg_q.odn;
    assign dat_v = rg_q.dat;
    assign msk_v = rg_q.msk;
    assign edg_v = rg_q.edg;

    gpio_in_sync #(.W(N_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_r),
        .level    (lvl_v),
        .rise     (rise_v),
        .fall     (fall_v)
    );

    assign cap_v = fall_v | (rise_v & ~edg_v);
    assign clr_v = (wr_en && sel == SEL_EVT) ? bus_wdata : '0;

    gpio_evt_reg #(.W(N_PINS)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (cap_v),
        .clr_vec (clr_v),
        .evt     (evt_v)
    );

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            case (sel)
                SEL_DIR: rg_d.dir = bus_wdata;
                SEL_ODN: rg_d.odn = bus_wdata;
                SEL_DAT: rg_d.dat = bus_wdata;
                SEL_MSK: rg_d.msk = bus_wdata;
                SEL_EDG: rg_d.edg = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (sel)
            SEL_DIR: bus_rdata = dir_v;
            SEL_ODN: bus_rdata = odn_v;
            SEL_DAT: bus_rdata = (lvl_v & ~dir_v) | (dat_v & dir_v);
            SEL_EVT: bus_rdata = evt_v;
            SEL_MSK: bus_rdata = msk_v;
            SEL_EDG: bus_rdata = edg_v;
            default: bus_rdata = '0;
        endcase
    end

    assign oe_r  = dir_v & ~(odn_v & dat_v);
    assign out_r = dat_v & ~odn_v;
    assign irq   = |(evt_v & msk_v);

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  evt,
    input logic [W-1:0]  cap,
    input logic [W-1:0]  fall,
    input logic [W-1:0]  edg,
    input logic [W-1:0]  dir,
    input logic [W-1:0]  odn,
    input logic [W-1:0]  msk,
    input logic [W-1:0]  oe_r,
    input logic [W-1:0]  out_r,
    input logic          irq
);

    logic evt_wr;
    assign evt_wr = bus_sel && bus_wr && (8'(bus_addr) == OFS_EVT);

    assert_evt_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr |=> ((evt & $past(bus_wdata) & ~$past(cap)) == '0));

    assert_evt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_wr |=> ((~evt & $past(evt)) == '0));

    assert_capture_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap != '0) |=> (($past(cap) & ~evt) == '0));

    assert_fall_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edg != '0) |=> ((evt & ~$past(evt) & $past(edg & ~fall)) == '0));

    assert_input_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((oe_r & ~dir) == '0));

    assert_odn_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((oe_r & out_r & odn) == '0));

    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & msk) == '0) |-> !irq);

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.W(N_PINS), .AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt       (evt_v),
    .cap       (cap_v),
    .fall      (fall_v),
    .edg       (edg_v),
    .dir       (dir_v),
    .odn       (odn_v),
    .msk       (msk_v),
    .oe_r      (oe_r),
    .out_r     (out_r),
    .irq       (irq)
);

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;

    localparam logic [4:0] A_DIR = 5'h00;
    localparam logic [4:0] A_ODN = 5'h04;
    localparam logic [4:0] A_DAT = 5'h08;
    localparam logic [4:0] A_EVT = 5'h0C;
    localparam logic [4:0] A_MSK = 5'h10;
    localparam logic [4:0] A_EDG = 5'h14;
    localparam logic [4:0] A_BAD = 5'h18;

    localparam int NV = 6;
    localparam logic [4:0]  T_ADDR [NV] = '{A_DIR, A_ODN, A_MSK, A_EDG, A_DAT, A_BAD};
    localparam logic [31:0] T_WR   [NV] = '{32'hF0F0_0000, 32'h0000_FFFF, 32'h1234_5678,
                                            32'hA5A5_A5A5, 32'hFFFF_0000, 32'hDEAD_BEEF};
    localparam logic [31:0] T_EXP  [NV] = '{32'hF0F0_0000, 32'h0000_FFFF, 32'h1234_5678,
                                            32'hA5A5_A5A5, 32'hF0F0_0000, 32'h0000_0000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_oe;
    logic [31:0] pin_out;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gpio_edge_ctrl i_gpio_edge_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // called just after a falling edge; commits on the next rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3: reset state
        rd_check("R3 dir", A_DIR, 32'h0);
        rd_check("R3 evt", A_EVT, 32'h0);
        rd_check("R3 msk", A_MSK, 32'h0);
        check("R3 pin_oe", pin_oe, 32'h0);
        check("R3 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: register readback table
        for (int i = 0; i < NV; i++) begin
            wr(T_ADDR[i], T_WR[i]);
            rd_check($sformatf("R2 table %0d", i), T_ADDR[i], T_EXP[i]);
        end
        wr(A_DIR, 0); wr(A_ODN, 0); wr(A_MSK, 0); wr(A_EDG, 0); wr(A_DAT, 0);

        // R4 / R1: pin 0 push-pull output on bit 31
        wr(A_DIR, 32'h8000_0000);
        wr(A_DAT, 32'h8000_0000);
        check("R1 R4 oe pin0", pin_oe, 32'h0000_0001);
        check("R4 out high", pin_out & pin_oe, 32'h0000_0001);
        wr(A_DAT, 32'h0);
        check("R4 out low", pin_out & pin_oe, 32'h0);
        check("R4 still driven", pin_oe, 32'h0000_0001);

        // R5: open drain
        wr(A_ODN, 32'h8000_0000);
        wr(A_DAT, 32'h8000_0000);
        check("R5 released", pin_oe, 32'h0);
        wr(A_DAT, 32'h0);
        check("R5 drives low oe", pin_oe, 32'h0000_0001);
        check("R5 drives low val", pin_out & pin_oe, 32'h0);
        wr(A_ODN, 0); wr(A_DIR, 0);

        // R6: output pin reads the written value, not the pin
        wr(A_DIR, 32'h0000_0001);
        wr(A_DAT, 32'h0000_0001);
        rd_check("R6 output readback", A_DAT, 32'h0000_0001);
        wr(A_DAT, 0); wr(A_DIR, 0);
        repeat (4) @(negedge clk);
        wr(A_EVT, 32'hFFFF_FFFF);
        rd_check("R9 cleared", A_EVT, 32'h0);

        // R6 / R7 / R1: latency of level and event for pin 0
        pin_in[0] = 1'b1;
        @(negedge clk);
        rd_check("R6 level after 1 edge", A_DAT, 32'h0);
        @(negedge clk);
        rd_check("R6 level after 2 edges", A_DAT, 32'h8000_0000);
        rd_check("R7 no event after 2 edges", A_EVT, 32'h0);
        @(negedge clk);
        rd_check("R7 R1 rise event bit31", A_EVT, 32'h8000_0000);

        // R9: write zero keeps, write one clears
        wr(A_EVT, 32'h0);
        rd_check("R9 zero keeps", A_EVT, 32'h8000_0000);
        wr(A_EVT, 32'h7FFF_FFFF);
        rd_check("R9 other bits keep", A_EVT, 32'h8000_0000);
        wr(A_EVT, 32'h8000_0000);
        rd_check("R9 one clears", A_EVT, 32'h0);

        // R7: falling also captured in both-edge mode
        pin_in[0] = 1'b0;
        repeat (3) @(negedge clk);
        rd_check("R7 fall event", A_EVT, 32'h8000_0000);
        wr(A_EVT, 32'hFFFF_FFFF);

        // R8: falling-only on pin 3 (bit 28)
        wr(A_EDG, 32'h1000_0000);
        pin_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        rd_check("R8 rise ignored", A_EVT, 32'h0);
        pin_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        rd_check("R8 fall captured", A_EVT, 32'h1000_0000);
        wr(A_EVT, 32'hFFFF_FFFF);
        wr(A_EDG, 32'h0);

        // R10: clear lands on the same edge as the capture (pin 7, bit 24)
        pin_in[7] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(A_EVT, 32'hFFFF_FFFF);
        rd_check("R10 capture beats clear", A_EVT, 32'h0100_0000);
        wr(A_EVT, 32'hFFFF_FFFF);
        rd_check("R10 later clear works", A_EVT, 32'h0);

        // R11: interrupt from event AND mask
        pin_in[7] = 1'b0;
        repeat (3) @(negedge clk);
        wr(A_MSK, 32'h0080_0000);
        check("R11 other mask irq low", {31'b0, irq}, 32'h0);
        wr(A_MSK, 32'h0100_0000);
        check("R11 matching mask irq high", {31'b0, irq}, 32'h1);

        // R12: ack all, mask all
        pin_in[9] = 1'b1;
        repeat (4) @(negedge clk);
        wr(A_EVT, 32'hFFFF_FFFF);
        wr(A_MSK, 32'h0);
        rd_check("R12 evt empty", A_EVT, 32'h0);
        check("R12 irq low", {31'b0, irq}, 32'h0);

        summary();
        $finish;
    end

endmodule